// File: doc/BRIEF.md
# Dual 12-Bit Converter Code Load Interface

This block is the digital front end of a two-channel 12-bit digital-to-analog converter that an 8-bit processor bus loads. Each channel keeps two input registers: an 8-bit low register and a 4-bit high register. The processor writes them separately over the byte-wide data bus. A 12-bit second-rank register per channel stands behind the pair and drives that channel's converter code output.

A mode pin selects how the second rank behaves. With the pin low, the second rank follows the input registers on every clock. With the pin high, the second rank holds its value. In that mode a write strobe issued with chip select inactive copies both channels at once. An asynchronous clear zeroes the second rank only. The bus strobe is synchronised to the system clock, and a register write takes effect on the trailing (rising) edge of the strobe.

Top module: `dual_dac_load_if`

## Requirements
- R1: A write to address 00 loads channel A bits [7:0] from data[7:0]. Address 01 loads channel A bits [11:8] from data[3:0]. Address 10 loads channel B bits [7:0]. Address 11 loads channel B bits [11:8].
- R2: An input register changes only when wrN rises while csN is low. A strobe with csN high writes no input register.
- R3: With latchMode low, each output code equals its channel's input registers within 4 clock edges of the rising edge of wrN.
- R4: With latchMode high, register writes leave both output codes unchanged.
- R5: With latchMode high, a wrN pulse with csN high copies both channels' input registers to both outputs in the same cycle.
- R6: clrN low forces both codes to zero asynchronously. The input registers keep their contents, and a later transfer shows them.
- R7: A transfer strobe while clrN is low has no effect. After the release, the codes stay zero in latched mode.
- R8: rstN low clears the input registers and both codes to zero.
- R9: In a high-part write, data[7:4] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low, acts on its rising edge |
| addr | input | 2 | Register select |
| dataIn | input | 8 | Bus data |
| latchMode | input | 1 | 0: second rank follows; 1: second rank holds until a transfer |
| clrN | input | 1 | Asynchronous clear of the second rank, active low |
| codeA | output | 12 | Channel A converter code |
| codeB | output | 12 | Channel B converter code |

## Verification
Several faults stay hidden at first and show up on a later cycle. A stale or misdirected input register does not appear at the outputs in latched mode until the next transfer, so the bench always follows a sequence of partial loads with a transfer or a switch to follow mode. A clear that wrongly touched the input registers shows only on the first transfer after the release. A misaligned bus capture shows as wrong bits within four clock edges of the strobe edge.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  localparam int BUS_W  = 8;
  localparam int CODE_W = 12;
  localparam int HI_W   = CODE_W - BUS_W;
  localparam int NCH    = 2;

  typedef struct packed {
    logic [NCH-1:0] loadLo;
    logic [NCH-1:0] loadHi;
    logic           xfer;
    logic           follow;
  } ctrl_t;

  typedef struct packed {
    logic             csN;
    logic [1:0]       addr;
    logic [BUS_W-1:0] data;
  } bus_t;
endpackage

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] dataIn,
  input  logic             latchMode,
  output ctrl_t            ctl,
  output logic [BUS_W-1:0] wrData
);
  logic wrS1, wrS2, wrS3;
  logic updS1, updS2;
  bus_t busS1, busS2, held;
  logic rise, sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrS1 <= 1'b1; wrS2 <= 1'b1; wrS3 <= 1'b1;
      updS1 <= 1'b0; updS2 <= 1'b0;
      busS1 <= '{csN: 1'b1, addr: 2'b00, data: '0};
      busS2 <= '{csN: 1'b1, addr: 2'b00, data: '0};
      held  <= '{csN: 1'b1, addr: 2'b00, data: '0};
    end else begin
      wrS1 <= wrN;  wrS2 <= wrS1; wrS3 <= wrS2;
      updS1 <= latchMode; updS2 <= updS1;
      busS1 <= '{csN: csN, addr: addr, data: dataIn};
      busS2 <= busS1;
      if (!wrS2) held <= busS2;
    end
  end

  assign rise = wrS2 & ~wrS3;
  assign sel  = rise & ~held.csN;

  always_comb begin
    ctl = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      ctl.loadLo[ch] = sel && (held.addr[1] == ch[0]) && !held.addr[0];
      ctl.loadHi[ch] = sel && (held.addr[1] == ch[0]) &&  held.addr[0];
    end
    ctl.xfer   = rise & held.csN & updS2;
    ctl.follow = ~updS2;
  end
  assign wrData = held.data;

  p_one_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadLo, ctl.loadHi}));
  p_xfer_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xfer |-> ({ctl.loadLo, ctl.loadHi} == '0));
endmodule

// File: rtl/dac_load_dp.sv
module dac_load_dp
  import dac_load_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clrN,
  input  ctrl_t                       ctl,
  input  logic [BUS_W-1:0]            wrData,
  output logic [NCH-1:0][CODE_W-1:0]  code
);
  logic [NCH-1:0][CODE_W-1:0] inReg;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) inReg[ch] <= '0;
      else begin
        if (ctl.loadLo[ch]) inReg[ch][BUS_W-1:0] <= wrData;
        if (ctl.loadHi[ch]) inReg[ch][CODE_W-1:BUS_W] <= wrData[HI_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN or negedge clrN) begin
      if (!rstN || !clrN) code[ch] <= '0;
      else if (ctl.follow || ctl.xfer) code[ch] <= inReg[ch];
    end

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
      !clrN |-> (code[ch] == '0));
    p_follow_r3: assert property (@(posedge clk) disable iff (!rstN || !clrN)
      ctl.follow |=> (code[ch] == $past(inReg[ch])));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rstN || !clrN)
      (!ctl.follow && !ctl.xfer) |=> $stable(code[ch]));
    p_xfer_r5: assert property (@(posedge clk) disable iff (!rstN || !clrN)
      ctl.xfer |=> (code[ch] == $past(inReg[ch])));
  end
endmodule

// File: rtl/dual_dac_load_if.sv
module dual_dac_load_if
  import dac_load_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  dataIn,
  input  logic              latchMode,
  input  logic              clrN,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB
);
  ctrl_t ctl;
  logic [BUS_W-1:0] wrData;
  logic [NCH-1:0][CODE_W-1:0] code;

  dac_load_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .latchMode(latchMode), .ctl(ctl), .wrData(wrData)
  );

  dac_load_dp u_dp (
    .clk(clk), .rstN(rstN), .clrN(clrN), .ctl(ctl), .wrData(wrData),
    .code(code)
  );

  assign codeA = code[0];
  assign codeB = code[1];
endmodule

// File: tb/dual_dac_load_if_test.sv
`timescale 1ns/1ps
module dual_dac_load_if_test;
  logic clk = 1'b0;
  logic rstN = 1'b0, csN = 1'b1, wrN = 1'b1, latchMode = 1'b0, clrN = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] dataIn = 8'h00;
  logic [11:0] codeA, codeB;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_dac_load_if uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .latchMode(latchMode), .clrN(clrN),
    .codeA(codeA), .codeB(codeB)
  );

  // {latchMode, csN, addr[1:0], data[7:0], expA[11:0], expB[11:0]}
  localparam logic [35:0] VEC [10] = '{
    {1'b0, 1'b0, 2'b00, 8'h5A, 12'h05A, 12'h000},  // R1 A low
    {1'b0, 1'b0, 2'b01, 8'hF3, 12'h35A, 12'h000},  // R1 R9 A high
    {1'b0, 1'b0, 2'b10, 8'hC7, 12'h35A, 12'h0C7},  // R1 B low
    {1'b0, 1'b0, 2'b11, 8'h0E, 12'h35A, 12'hEC7},  // R1 R3 B high
    {1'b0, 1'b1, 2'b00, 8'hFF, 12'h35A, 12'hEC7},  // R2 no select
    {1'b1, 1'b0, 2'b00, 8'h11, 12'h35A, 12'hEC7},  // R4 held
    {1'b1, 1'b0, 2'b11, 8'h02, 12'h35A, 12'hEC7},  // R4 held
    {1'b1, 1'b1, 2'b00, 8'h00, 12'h311, 12'h2C7},  // R5 transfer
    {1'b1, 1'b0, 2'b01, 8'hFA, 12'h311, 12'h2C7},  // R4 R9 held
    {1'b0, 1'b1, 2'b00, 8'h00, 12'hA11, 12'h2C7}   // R3 follow again
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busOp(input logic c, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); csN = c; addr = a; dataIn = d;
    cyc(2); wrN = 1'b0;
    cyc(3); wrN = 1'b1;
    cyc(2); csN = 1'b1; dataIn = 8'h00;
    cyc(6);
  endtask

  task automatic setMode(input logic m);
    @(negedge clk); latchMode = m; cyc(4);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    cyc(3);
    check("R8 reset codeA", codeA, 12'h000);
    check("R8 reset codeB", codeB, 12'h000);
    @(negedge clk); rstN = 1'b1; cyc(3);

    for (int v = 0; v < 10; v++) begin
      if (latchMode != VEC[v][35]) setMode(VEC[v][35]);
      busOp(VEC[v][34], VEC[v][33:32], VEC[v][31:24]);
      check($sformatf("vector %0d codeA (R1-R5 table)", v), codeA, VEC[v][23:12]);
      check($sformatf("vector %0d codeB", v), codeB, VEC[v][11:0]);
    end

    // Clear: latched mode, stage new A low, then clear
    setMode(1'b1);
    busOp(1'b0, 2'b00, 8'h22);               // inA = A22
    check("R4 staged A held", codeA, 12'hA11);
    @(negedge clk); clrN = 1'b0; #1;
    check("R6 clear codeA", codeA, 12'h000);
    check("R6 clear codeB", codeB, 12'h000);
    busOp(1'b1, 2'b00, 8'h00);               // transfer during clear
    check("R7 xfer in clear A", codeA, 12'h000);
    @(negedge clk); clrN = 1'b1; cyc(3);
    check("R7 after release A", codeA, 12'h000);
    check("R7 after release B", codeB, 12'h000);
    busOp(1'b1, 2'b00, 8'h00);               // transfer shows kept inputs
    check("R6 inputs kept A", codeA, 12'hA22);
    check("R6 inputs kept B", codeB, 12'h2C7);

    // Reset mid-run clears inputs too
    @(negedge clk); rstN = 1'b0; #1;
    check("R8 reset A", codeA, 12'h000);
    @(negedge clk); rstN = 1'b1; latchMode = 1'b0; cyc(6);
    check("R8 inputs cleared A", codeA, 12'h000);
    check("R8 inputs cleared B", codeB, 12'h000);

    finishRun();
  end
endmodule